// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block is the synchronous control and data path of a wide pipelined burst memory with byte-lane writes. On every rising clock edge it samples three chip selects, a processor address strobe, a controller address strobe, a burst step input, an all-lanes write input, a lane write gate and one write enable per byte lane. From these it decides whether the edge starts a new access, continues a burst, holds a burst at its current address, deselects the device, or does nothing. The decision then drives an internal parameterized array.

Read data passes through two register stages, so a read sampled on one edge is driven on the second edge that follows. The output drive is gated by a registered selection state, by an asynchronous output enable and by a doze input. Writes are held in a one-entry pending register and committed one edge later. A read issued right after a write merges the pending lanes over the array word, so freshly written data is returned without a stall. A separate burst counter produces the low address bits in either a wrapping linear order or an XOR (interleaved) order.

Top module: `sbc_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `rdrive` is 0 and `rdata` is 0 until a read has passed through the pipeline.
- R2: A processor strobe (`cpu_stb_n` low) with `sel_a_n` low, `sel_b` high and `sel_c_n` low loads `addr_in` and reads it. With `out_en_n` low, the word appears on `rdata` with `rdrive` high only after the second rising edge (two-clock enable).
- R3: While `sel_a_n` is high, the processor strobe is ignored. If the controller strobe is also high and the device is deselected, nothing starts.
- R4: A processor-strobe start is always a read, even when the write decode is active. A write to that address is made by asserting the write decode on the next cycle with both strobes high and `step_n` high.
- R5: A controller strobe (`ctl_stb_n` low) with the processor strobe inactive and all three selects active loads `addr_in`. It writes if the write decode is active and reads otherwise.
- R6: The write decode is active when `wr_all_n` is low, which writes all lanes. It is also active when `lane_gate_n` is low and some `lane_wr_n[i]` is low, which writes lane i only, covering `wdata` bits 8i+7 down to 8i. When `lane_gate_n` is high, the lane enables have no effect.
- R7: With both strobes high while selected, `step_n` low moves to the next burst address and `step_n` high stays on the current one. Read or write follows the write decode.
- R8: The burst order is taken from the two low address bits. With `burst_lin` high, the low bits are base+count modulo 4. With `burst_lin` low, they are base XOR count. The count runs 0,1,2,3 and the upper address bits stay fixed.
- R9: A strobe cycle with `sel_b` low or `sel_c_n` high deselects the device. `rdrive` falls after that one edge, and later strobe-free cycles neither read nor write.
- R10: `out_en_n` high turns `rdrive` off immediately, without a clock edge.
- R11: After an edge that performs a write, `rdrive` is 0 for the following cycle.
- R12: A read issued on the edge right after a write returns the new data in the written lanes and the previous array data in the other lanes.
- R13: While `doze` is high, `rdrive` is 0, no access starts, continues or writes, and the stored words and the selection state are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | ADDR_W | Word address loaded on a strobe start |
| wdata | input | LANES*LANE_W | Write data sampled on write edges |
| sel_a_n | input | 1 | Active-low select that also masks the processor strobe |
| sel_b | input | 1 | Active-high select, sampled only on strobe cycles |
| sel_c_n | input | 1 | Active-low select, sampled only on strobe cycles |
| cpu_stb_n | input | 1 | Processor address strobe, starts reads only |
| ctl_stb_n | input | 1 | Controller address strobe, starts reads or writes |
| step_n | input | 1 | Low advances the burst address |
| burst_lin | input | 1 | High selects linear order, low selects interleaved order |
| wr_all_n | input | 1 | Low writes all byte lanes |
| lane_gate_n | input | 1 | Low lets the per-lane write enables act |
| lane_wr_n | input | LANES | Per-lane active-low write enables |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| doze | input | 1 | Blocks outputs and new cycles |
| rdata | output | LANES*LANE_W | Read data, zero while not driven |
| rdrive | output | 1 | High while `rdata` is driven |

## Verification
Full-word writes fill the array with an address-dependent pattern. Reads then arrive through both strobes, and any address or lane mix-up shows as a wrong word. Bursts from base address 5 are run in both orders, because linear (5,6,7,4) and interleaved (5,4,7,6) differ from the second beat on. Partial-lane writes followed at once by a read separate a correct lane-wise pass-through from a whole-word or stale result. Masked strobes, deselects, doze and output-enable toggles are each followed by a read-back of the affected word, to show whether a write or a start leaked through.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_DESEL = 2'd1,
    OP_READ  = 2'd2,
    OP_WRITE = 2'd3
  } sbc_op_e;
endpackage

// File: rtl/sbc_cmd_decode.sv
module sbc_cmd_decode
  import sbc_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic             doze,
  input  logic             cpu_stb_n,
  input  logic             ctl_stb_n,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             step_n,
  input  logic             wr_all_n,
  input  logic             lane_gate_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             act_q,
  output sbc_op_e          op,
  output logic             load,
  output logic             advance,
  output logic             act_set,
  output logic             act_clr,
  output logic [LANES-1:0] lane_mask
);
  logic [LANES-1:0] wr_mask;
  logic             wr_req;
  logic             cpu_go;
  logic             sel_ok;

  always_comb begin
    if (!wr_all_n)         wr_mask = '1;
    else if (!lane_gate_n) wr_mask = ~lane_wr_n;
    else                   wr_mask = '0;
    wr_req = |wr_mask;
    cpu_go = !cpu_stb_n && !sel_a_n;
    sel_ok = !sel_a_n && sel_b && !sel_c_n;
  end

  always_comb begin
    op      = OP_IDLE;
    load    = 1'b0;
    advance = 1'b0;
    act_set = 1'b0;
    act_clr = 1'b0;
    if (!doze) begin
      if (cpu_go) begin
        // processor strobe: read only, outer selects checked here
        if (sel_b && !sel_c_n) begin
          op      = OP_READ;
          load    = 1'b1;
          act_set = 1'b1;
        end else begin
          op      = OP_DESEL;
          act_clr = 1'b1;
        end
      end else if (!ctl_stb_n) begin
        if (sel_ok) begin
          op      = wr_req ? OP_WRITE : OP_READ;
          load    = 1'b1;
          act_set = 1'b1;
        end else begin
          op      = OP_DESEL;
          act_clr = 1'b1;
        end
      end else if (act_q) begin
        op      = wr_req ? OP_WRITE : OP_READ;
        advance = !step_n;
      end
    end
    lane_mask = (op == OP_WRITE) ? wr_mask : '0;
  end
endmodule

// File: rtl/sbc_burst_ctr.sv
module sbc_burst_ctr #(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic              linear,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_eff
);
  logic [ADDR_W-1:0]  base_q, base_d;
  logic [BURST_W-1:0] cnt_q, cnt_d;
  logic [BURST_W-1:0] low;

  always_comb begin
    base_d = load ? addr_in : base_q;
    if (load)         cnt_d = '0;
    else if (advance) cnt_d = cnt_q + 1'b1;
    else              cnt_d = cnt_q;
    if (linear) low = base_d[BURST_W-1:0] + cnt_d;
    else        low = base_d[BURST_W-1:0] ^ cnt_d;
    addr_eff = {base_d[ADDR_W-1:BURST_W], low};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load || advance) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/sbc_store.sv
module sbc_store #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_req,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic                    rd_vld_q,
  output logic [LANES*LANE_W-1:0] rd_data_q
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  logic              pend_vld_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_data_q;
  logic [LANES-1:0]  pend_mask_q;

  logic              wr_go;
  logic              hit;
  logic [DATA_W-1:0] raw;
  logic [DATA_W-1:0] merged;

  assign wr_go = |wr_mask;
  assign raw   = mem_q[addr];
  assign hit   = pend_vld_q && (pend_addr_q == addr);

  // lane-wise pass-through of the write still waiting to commit
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*LANE_W +: LANE_W] = (hit && pend_mask_q[g]) ?
        pend_data_q[g*LANE_W +: LANE_W] : raw[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (pend_vld_q) begin
      for (int i = 0; i < LANES; i++) begin
        if (pend_mask_q[i]) mem_q[pend_addr_q][i*LANE_W +: LANE_W] <= pend_data_q[i*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld_q  <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
      pend_mask_q <= '0;
    end else begin
      pend_vld_q <= wr_go;
      if (wr_go) begin
        pend_addr_q <= addr;
        pend_data_q <= wdata;
        pend_mask_q <= wr_mask;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld_q  <= 1'b0;
      rd_data_q <= '0;
    end else begin
      rd_vld_q <= rd_req;
      if (rd_req) rd_data_q <= merged;
    end
  end
endmodule

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
  import sbc_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 8,
  parameter int LANE_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr_in,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    cpu_stb_n,
  input  logic                    ctl_stb_n,
  input  logic                    step_n,
  input  logic                    burst_lin,
  input  logic                    wr_all_n,
  input  logic                    lane_gate_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    out_en_n,
  input  logic                    doze,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdrive
);
  localparam int DATA_W = LANES * LANE_W;

  sbc_op_e           op;
  logic              load, advance, act_set, act_clr;
  logic [LANES-1:0]  lane_mask;
  logic              act_q, act_d;
  logic [ADDR_W-1:0] addr_eff;
  logic              rd_vld_q;
  logic [DATA_W-1:0] rd_data_q;
  logic              out_vld_q, out_vld_d;
  logic [DATA_W-1:0] out_data_q;

  sbc_cmd_decode #(.LANES(LANES)) u_dec (
    .doze        (doze),
    .cpu_stb_n   (cpu_stb_n),
    .ctl_stb_n   (ctl_stb_n),
    .sel_a_n     (sel_a_n),
    .sel_b       (sel_b),
    .sel_c_n     (sel_c_n),
    .step_n      (step_n),
    .wr_all_n    (wr_all_n),
    .lane_gate_n (lane_gate_n),
    .lane_wr_n   (lane_wr_n),
    .act_q       (act_q),
    .op          (op),
    .load        (load),
    .advance     (advance),
    .act_set     (act_set),
    .act_clr     (act_clr),
    .lane_mask   (lane_mask)
  );

  sbc_burst_ctr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .advance  (advance),
    .linear   (burst_lin),
    .addr_in  (addr_in),
    .addr_eff (addr_eff)
  );

  sbc_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (op == OP_READ),
    .wr_mask   (lane_mask),
    .addr      (addr_eff),
    .wdata     (wdata),
    .rd_vld_q  (rd_vld_q),
    .rd_data_q (rd_data_q)
  );

  always_comb begin
    if (act_set)      act_d = 1'b1;
    else if (act_clr) act_d = 1'b0;
    else              act_d = act_q;
    // disable reaches the output in one edge, enable needs two
    out_vld_d = rd_vld_q && (op != OP_DESEL) && (op != OP_WRITE) && !doze;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q      <= 1'b0;
      out_vld_q  <= 1'b0;
      out_data_q <= '0;
    end else begin
      act_q     <= act_d;
      out_vld_q <= out_vld_d;
      if (rd_vld_q) out_data_q <= rd_data_q;
    end
  end

  assign rdrive = out_vld_q && !out_en_n && !doze;
  assign rdata  = rdrive ? out_data_q : '0;
endmodule

// File: rtl/sbc_ctrl_chk.sv
module sbc_ctrl_chk #(
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             doze,
  input logic             cpu_stb_n,
  input logic             ctl_stb_n,
  input logic             sel_a_n,
  input logic             sel_b,
  input logic             sel_c_n,
  input logic             wr_all_n,
  input logic             lane_gate_n,
  input logic [LANES-1:0] lane_wr_n,
  input logic             rdrive,
  input logic             act_q
);
  logic wdec;
  assign wdec = !wr_all_n || (!lane_gate_n && !(&lane_wr_n));

  // R11
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!doze && cpu_stb_n && !ctl_stb_n && !sel_a_n && sel_b && !sel_c_n && wdec) |=> !rdrive);

  // R9
  desel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!doze && !ctl_stb_n && !sel_b) |=> !rdrive);

  // R13
  doze_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdrive |-> (!$past(doze) && !$past(doze, 2)));

  // R3
  masked_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && sel_a_n && ctl_stb_n) |=> !act_q);

  // R7
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && cpu_stb_n && ctl_stb_n) |=> act_q);
endmodule

bind sbc_ctrl sbc_ctrl_chk #(.LANES(LANES)) u_sbc_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .doze        (doze),
  .cpu_stb_n   (cpu_stb_n),
  .ctl_stb_n   (ctl_stb_n),
  .sel_a_n     (sel_a_n),
  .sel_b       (sel_b),
  .sel_c_n     (sel_c_n),
  .wr_all_n    (wr_all_n),
  .lane_gate_n (lane_gate_n),
  .lane_wr_n   (lane_wr_n),
  .rdrive      (rdrive),
  .act_q       (act_q)
);

// File: tb/sbc_ctrl_tb_top.sv
module sbc_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr_in = '0;
  logic [63:0] wdata = '0;
  logic        sel_a_n = 1'b1, sel_b = 1'b1, sel_c_n = 1'b0;
  logic        cpu_stb_n = 1'b1, ctl_stb_n = 1'b1, step_n = 1'b1;
  logic        burst_lin = 1'b1;
  logic        wr_all_n = 1'b1, lane_gate_n = 1'b1;
  logic [7:0]  lane_wr_n = 8'hFF;
  logic        out_en_n = 1'b0, doze = 1'b0;
  logic [63:0] rdata;
  logic        rdrive;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  sbc_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .wdata(wdata),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .step_n(step_n),
    .burst_lin(burst_lin), .wr_all_n(wr_all_n), .lane_gate_n(lane_gate_n),
    .lane_wr_n(lane_wr_n), .out_en_n(out_en_n), .doze(doze),
    .rdata(rdata), .rdrive(rdrive)
  );

  // behavioural reference model
  logic [63:0] m_mem   [64];
  logic [63:0] m_known [64] = '{default: 64'd0};
  bit          m_act, m_rd1, m_ov;
  logic [63:0] m_rd1d, m_rd1k, m_od, m_ok;
  int          m_base, m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_rd1 = 0; m_ov = 0; m_base = 0; m_cnt = 0;
      m_od = '0; m_ok = '0; m_rd1d = '0; m_rd1k = '0;
    end else begin
      logic [7:0] wm;
      int op, lo, ea;
      bit ld, adv;
      if (!wr_all_n) wm = 8'hFF;
      else if (!lane_gate_n) wm = ~lane_wr_n;
      else wm = 8'h00;
      op = 0; ld = 0; adv = 0;
      if (!doze) begin
        if (!cpu_stb_n && !sel_a_n) begin
          if (sel_b && !sel_c_n) begin op = 2; ld = 1; end else op = 1;
        end else if (!ctl_stb_n) begin
          if (!sel_a_n && sel_b && !sel_c_n) begin op = (wm != 0) ? 3 : 2; ld = 1; end
          else op = 1;
        end else if (m_act) begin
          op = (wm != 0) ? 3 : 2; adv = !step_n;
        end
      end
      if (ld) begin m_base = int'(addr_in); m_cnt = 0; end
      else if (adv) m_cnt = (m_cnt + 1) % 4;
      lo = burst_lin ? ((m_base % 4) + m_cnt) % 4 : ((m_base % 4) ^ m_cnt);
      ea = (m_base / 4) * 4 + lo;
      if (ld) m_act = 1;
      if (op == 1) m_act = 0;
      m_ov = m_rd1 && (op != 1) && (op != 3) && !doze;
      if (m_rd1) begin m_od = m_rd1d; m_ok = m_rd1k; end
      m_rd1 = (op == 2);
      if (op == 2) begin m_rd1d = m_mem[ea]; m_rd1k = m_known[ea]; end
      if (op == 3) begin
        for (int i = 0; i < 8; i++) begin
          if (wm[i]) begin
            m_mem[ea][i*8 +: 8] = wdata[i*8 +: 8];
            m_known[ea][i*8 +: 8] = 8'hFF;
          end
        end
      end
    end
  end

  function automatic logic [63:0] pat(input int a);
    return {8{8'(a)}} ^ 64'h0123_4567_89AB_CDEF;
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic compare();
    bit ed;
    ed = m_ov && !out_en_n && !doze;
    chk(cur_req, {63'd0, rdrive}, {63'd0, ed});
    if (ed) chk(cur_req, rdata & m_ok, m_od & m_ok);
    else    chk(cur_req, rdata, 64'd0);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    sel_a_n = 1; sel_b = 1; sel_c_n = 0;
    cpu_stb_n = 1; ctl_stb_n = 1; step_n = 1;
    wr_all_n = 1; lane_gate_n = 1; lane_wr_n = 8'hFF;
  endtask

  task automatic ctl_start(input int a);
    idle(); sel_a_n = 0; ctl_stb_n = 0; addr_in = 6'(a);
  endtask

  task automatic cpu_start(input int a);
    idle(); sel_a_n = 0; cpu_stb_n = 0; addr_in = 6'(a);
  endtask

  task automatic deselect();
    idle(); sel_a_n = 0; ctl_stb_n = 0; sel_b = 0;
  endtask

  task automatic burst_run(input bit lin, input int b0, input int b1, input int b2, input int b3);
    burst_lin = lin;
    ctl_start(5); step();
    idle(); step_n = 0;
    step(); chk(cur_req, rdata, pat(b0));
    step(); chk(cur_req, rdata, pat(b1));
    step(); chk(cur_req, rdata, pat(b2));
    idle(); step(); chk(cur_req, rdata, pat(b3));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired got hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (2) @(negedge clk);
    chk("R1", {63'd0, rdrive}, 64'd0);
    chk("R1", rdata, 64'd0);
    rst_n = 1;
    step(); step();

    // R5/R6: fill words 0..31 through controller-strobe full writes
    cur_req = "R5";
    for (int a = 0; a < 32; a++) begin
      ctl_start(a); wr_all_n = 0; wdata = pat(a); step();
    end
    idle(); step(); step();

    // R2: processor-strobe read, two-clock enable
    cur_req = "R2";
    deselect(); step();
    cpu_start(5); step();
    chk("R2", {63'd0, rdrive}, 64'd0);
    idle(); step();
    chk("R2", {63'd0, rdrive}, 64'd1);
    chk("R2", rdata, pat(5));

    // R8: linear 5,6,7,4 then interleaved 5,4,7,6
    cur_req = "R8";
    burst_run(1'b1, 5, 6, 7, 4);
    burst_run(1'b0, 5, 4, 7, 6);
    burst_lin = 1;

    // R7: suspend keeps the address, continue moves it
    cur_req = "R7";
    ctl_start(8); step();
    idle(); step(); chk("R7", rdata, pat(8));
    step(); chk("R7", rdata, pat(8));
    step_n = 0; step(); step(); chk("R7", rdata, pat(9));

    // R10: asynchronous output enable
    cur_req = "R10";
    idle(); step();
    out_en_n = 1; #1;
    chk("R10", {63'd0, rdrive}, 64'd0);
    chk("R10", rdata, 64'd0);
    out_en_n = 0; #1;
    chk("R10", {63'd0, rdrive}, 64'd1);
    step();

    // R4 + R11: processor start ignores write decode, write on next wait cycle
    cur_req = "R4";
    cpu_start(9); wr_all_n = 0; wdata = 64'hDEAD_BEEF_DEAD_BEEF; step();
    idle(); lane_gate_n = 0; lane_wr_n = 8'hFE; wdata = 64'h0000_0000_0000_00C3; step();
    chk("R11", {63'd0, rdrive}, 64'd0);
    idle(); ctl_start(9); step();
    idle(); step();
    chk("R4", rdata, {pat(9)[63:8], 8'hC3});

    // R12: partial write then immediate read
    cur_req = "R12";
    ctl_start(20); lane_gate_n = 0; lane_wr_n = 8'hF0; wdata = 64'h1111_2222_3333_4444; step();
    ctl_start(20); step();
    idle(); step();
    chk("R12", rdata, {pat(20)[63:32], 32'h3333_4444});
    ctl_start(21); wr_all_n = 0; wdata = 64'h0F0F_F0F0_5A5A_A5A5; step();
    ctl_start(21); step();
    idle(); step();
    chk("R12", rdata, 64'h0F0F_F0F0_5A5A_A5A5);

    // R6: lane gate high makes lane enables inert (controller strobe reads)
    cur_req = "R6";
    ctl_start(22); lane_gate_n = 1; lane_wr_n = 8'h00; wdata = '1; step();
    idle(); step();
    chk("R6", rdata, pat(22));

    // R9: deselect drops output in one edge, no later writes
    cur_req = "R9";
    ctl_start(12); step();
    idle(); step(); step();
    chk("R9", {63'd0, rdrive}, 64'd1);
    idle(); sel_a_n = 0; ctl_stb_n = 0; sel_c_n = 1; step();
    chk("R9", {63'd0, rdrive}, 64'd0);
    idle(); wr_all_n = 0; wdata = '0; step(); step();
    chk("R9", {63'd0, rdrive}, 64'd0);
    idle(); ctl_start(12); step();
    idle(); step();
    chk("R9", rdata, pat(12));

    // R3: masked processor strobe while deselected starts nothing
    cur_req = "R3";
    deselect(); step();
    idle(); sel_a_n = 1; cpu_stb_n = 0; addr_in = 6'd3;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R3", {63'd0, rdrive}, 64'd0);
    end

    // R13: doze blocks output and cycles, keeps contents and selection
    cur_req = "R13";
    ctl_start(14); step();
    idle(); step(); step();
    doze = 1; #1;
    chk("R13", {63'd0, rdrive}, 64'd0);
    ctl_start(14); wr_all_n = 0; wdata = 64'h7777_7777_7777_7777; step();
    chk("R13", {63'd0, rdrive}, 64'd0);
    idle(); step();
    doze = 0; step(); step();
    chk("R13", {63'd0, rdrive}, 64'd1);
    chk("R13", rdata, pat(14));

    idle(); step(); step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule